// File: doc/BRIEF.md
# Canonical Signed Digit Encoder

This block recodes an unsigned binary constant into canonical signed-digit (CSD) form. Every output digit is one of -1, 0 or +1, and no two neighbouring digits are both nonzero. A multiply by the constant can then be built from hardwired shifts, with one addition or subtraction for each nonzero digit. The recoding works by carry propagation. Any run of two or more adjacent ones is folded into a +1 just above the run and a -1 at its lowest position. This holds because the sum 2^(k-1)+...+2^0 equals 2^k - 1.

The encoder takes one word over a valid/ready input stream. It walks the word from the least significant bit upward, producing one digit per clock cycle with a single carry bit, for N+1 digits in all. The extra top digit holds a carry out of bit N-1. While it produces digits it also counts the nonzero digits and sums digit·2^i back into an integer, so the conversion can be checked by whatever consumes the result. The result is offered on a valid/ready output stream. It stays held until the consumer takes it, and the input is not ready again until then. A plain `done` pin pulses once when each result first appears.

Top module: `csd_encoder`

## Requirements
- R1: Digit i sits in bits [2i+1:2i] of `out_digits`, coded 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1. The code 2'b10 never appears while `out_valid` is high.
- R2: The sum over i of digit_i·2^i equals the accepted input word.
- R3: No two adjacent digits of a result are both nonzero.
- R4: `out_nz_count` equals the number of nonzero digits and never exceeds floor((N+2)/2), which is 5 for N = 8.
- R5: `out_value`, read as a two's-complement number, equals the accepted input word while `out_valid` is high.
- R6: A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only in the idle state, so it is low from the cycle after acceptance until the result has been taken. `in_valid` and `in_data` are ignored while `in_ready` is low.
- R7: `out_valid` rises exactly N+1 clock cycles after the accepting edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_digits`, `out_nz_count` and `out_value` hold steady. After an edge with `out_valid` and `out_ready` both high, `out_valid` is low and `in_ready` is high.
- R9: `done` is high for exactly one cycle, namely the first cycle in which `out_valid` is high.
- R10: After reset, `in_ready` is 1, and `out_valid`, `done` and `out_digits` are 0.
- R11: Known encodings (N = 8). Input 111 gives +1 at digit 7, -1 at digit 4 and -1 at digit 0. Input 255 gives +1 at digit 8 and -1 at digit 0. Input 171 gives five nonzero digits. Input 0 gives all zero digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Encoder is idle and will take a word |
| in_data | input | N | Unsigned constant to recode |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_digits | output | 2(N+1) | Signed digits, 2 bits each, digit 0 lowest |
| out_nz_count | output | clog2(N+2) | Number of nonzero digits |
| out_value | output | N+2 | Recoded value summed back, two's complement |
| done | output | 1 | One-cycle pulse when a result first appears |

## Verification
The result of an accepted word is due N+1 rising edges after the accepting edge. The `done` pulse is due on that same edge. `in_ready` drops one edge after acceptance. Output release is visible one edge after `out_ready` is sampled high. The bench drives and samples on falling edges and counts rising edges from acceptance until `out_valid` is seen, so the latency is measured exactly and not merely waited out. Results are checked at that point and again after extra stalled cycles. Every 8-bit input is checked for value, adjacency and count, and the encodings listed in R11 are checked digit by digit.

// File: rtl/csd_pkg.sv
package csd_pkg;
  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_POS  = 2'b01,
    DIG_NEG  = 2'b11
  } csd_digit_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_HOLD = 2'b10
  } csd_state_e;
endpackage

// File: rtl/csd_digit_cell.sv
module csd_digit_cell
  import csd_pkg::*;
(
  input  logic       cur_bit,
  input  logic       next_bit,
  input  logic       carry_in,
  output csd_digit_e digit,
  output logic       carry_out
);
  always_comb begin
    digit     = DIG_ZERO;
    carry_out = 1'b0;
    if (cur_bit && carry_in) begin
      carry_out = 1'b1;
    end else if (cur_bit || carry_in) begin
      // a lone one becomes +1; the start of a run becomes -1 with a carry
      if (next_bit) begin
        digit     = DIG_NEG;
        carry_out = 1'b1;
      end else begin
        digit = DIG_POS;
      end
    end
  end
endmodule

// File: rtl/csd_seq_ctrl.sv
module csd_seq_ctrl
  import csd_pkg::*;
#(
  parameter int STEPS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load,
  output logic step,
  output logic done
);
  localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  csd_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign load      = in_ready && in_valid;
  assign step      = (state_q == ST_RUN);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (in_valid) begin
          state_q <= ST_RUN;
          idx_q   <= '0;
        end
        ST_RUN: if (idx_q == IDX_W'(STEPS - 1)) begin
          state_q <= ST_HOLD;
          done_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  take_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

// File: rtl/csd_value_accum.sv
module csd_value_accum
  import csd_pkg::*;
#(
  parameter int DIGITS = 9,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  csd_digit_e        digit,
  output logic [DIGITS:0]   value,
  output logic [CNT_W-1:0]  nz_count
);
  localparam int VAL_W = DIGITS + 1;

  logic [VAL_W-1:0] weight_q;
  logic [VAL_W-1:0] value_q;
  logic [CNT_W-1:0] nz_q;

  assign value    = value_q;
  assign nz_count = nz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      weight_q <= VAL_W'(1);
      value_q  <= '0;
      nz_q     <= '0;
    end else if (load) begin
      weight_q <= VAL_W'(1);
      value_q  <= '0;
      nz_q     <= '0;
    end else if (step) begin
      weight_q <= weight_q << 1;
      unique case (digit)
        DIG_POS: begin
          value_q <= value_q + weight_q;
          nz_q    <= nz_q + 1'b1;
        end
        DIG_NEG: begin
          value_q <= value_q - weight_q;
          nz_q    <= nz_q + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/csd_encoder.sv
module csd_encoder
  import csd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [N-1:0]                 in_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [2*(N+1)-1:0]           out_digits,
  output logic [$clog2(N+2)-1:0]       out_nz_count,
  output logic [N+1:0]                 out_value,
  output logic                         done
);
  localparam int DIG_N = N + 1;
  localparam int VEC_W = 2 * DIG_N;
  localparam int CNT_W = $clog2(N + 2);
  localparam int NZ_MAX = (N + 2) / 2;

  logic             load, step;
  logic [N:0]       bits_q;
  logic             carry_q;
  logic [VEC_W-1:0] digits_q;
  logic [N-1:0]     word_q;
  csd_digit_e       cell_digit;
  logic             cell_carry;

  csd_seq_ctrl #(.STEPS(DIG_N)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .load(load), .step(step),
    .done(done)
  );

  csd_digit_cell cell_i (
    .cur_bit(bits_q[0]), .next_bit(bits_q[1]), .carry_in(carry_q),
    .digit(cell_digit), .carry_out(cell_carry)
  );

  csd_value_accum #(.DIGITS(DIG_N), .CNT_W(CNT_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .digit(cell_digit),
    .value(out_value), .nz_count(out_nz_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q   <= '0;
      carry_q  <= 1'b0;
      digits_q <= '0;
      word_q   <= '0;
    end else if (load) begin
      bits_q   <= {1'b0, in_data};
      carry_q  <= 1'b0;
      digits_q <= '0;
      word_q   <= in_data;
    end else if (step) begin
      bits_q   <= {1'b0, bits_q[N:1]};
      carry_q  <= cell_carry;
      digits_q <= {cell_digit, digits_q[VEC_W-1:2]};
    end
  end

  assign out_digits = digits_q;

  // helper flags for the output checks
  logic adj_hit, bad_code;
  always_comb begin
    adj_hit  = 1'b0;
    bad_code = 1'b0;
    for (int i = 0; i < DIG_N; i++) begin
      if (digits_q[2*i +: 2] == 2'b10) bad_code = 1'b1;
      if (i > 0 && digits_q[2*i] && digits_q[2*i-2]) adj_hit = 1'b1;
    end
  end

  // R1
  digit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !bad_code);
  // R3
  no_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !adj_hit);
  // R4
  nz_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nz_count <= CNT_W'(NZ_MAX)));
  // R5
  value_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_value == {2'b00, word_q}));
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_digits) && $stable(out_value)));
  // R9
  done_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);
endmodule

// File: tb/csd_encoder_tb.sv
module csd_encoder_tb_top;
  localparam int N = 8;
  localparam int DIG_N = N + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [2*DIG_N-1:0] out_digits;
  logic [$clog2(N+2)-1:0] out_nz_count;
  logic [N+1:0] out_value;
  logic done;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  csd_encoder #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_digits(out_digits), .out_nz_count(out_nz_count),
    .out_value(out_value), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dig_val(input logic [1:0] c);
    case (c)
      2'b01: return 1;
      2'b11: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic int sum_digits(input logic [2*DIG_N-1:0] v);
    int s = 0;
    for (int i = 0; i < DIG_N; i++) s += dig_val(v[2*i +: 2]) * (1 << i);
    return s;
  endfunction

  function automatic int count_nz(input logic [2*DIG_N-1:0] v);
    int c = 0;
    for (int i = 0; i < DIG_N; i++) if (v[2*i +: 2] != 2'b00) c++;
    return c;
  endfunction

  function automatic int count_adj(input logic [2*DIG_N-1:0] v);
    int c = 0;
    for (int i = 1; i < DIG_N; i++)
      if (v[2*i +: 2] != 2'b00 && v[2*i-2 +: 2] != 2'b00) c++;
    return c;
  endfunction

  function automatic int count_bad_code(input logic [2*DIG_N-1:0] v);
    int c = 0;
    for (int i = 0; i < DIG_N; i++) if (v[2*i +: 2] == 2'b10) c++;
    return c;
  endfunction

  // offer a word, return rising edges from acceptance to out_valid
  task automatic send(input int val, output int lat);
    @(negedge clk);
    in_data  = N'(val);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 40) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic release_out();
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid, "R8 out_valid after take", out_valid, 0);
    chk(in_ready, "R8 in_ready after take", in_ready, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    chk(done == 1'b0, "R10 done", done, 0);
    chk(out_digits == '0, "R10 digits", int'(out_digits), 0);
  endtask

  task automatic t_known(input int val, input int pos_at, input int neg_a, input int neg_b, input int nz);
    int lat;
    logic [2*DIG_N-1:0] exp_v = '0;
    if (pos_at >= 0) exp_v[2*pos_at +: 2] = 2'b01;
    if (neg_a >= 0)  exp_v[2*neg_a +: 2]  = 2'b11;
    if (neg_b >= 0)  exp_v[2*neg_b +: 2]  = 2'b11;
    send(val, lat);
    chk(lat == DIG_N, "R7 latency", lat, DIG_N);
    if (nz >= 0) chk(out_digits == exp_v, "R11 digit pattern", int'(out_digits), int'(exp_v));
    chk(count_nz(out_digits) == (nz >= 0 ? nz : 5), "R11 nonzero digits", count_nz(out_digits), nz >= 0 ? nz : 5);
    release_out();
  endtask

  task automatic t_exhaustive();
    int lat;
    for (int v = 0; v < (1 << N); v++) begin
      send(v, lat);
      chk(lat == DIG_N, "R7 latency", lat, DIG_N);
      chk(done == 1'b1, "R9 done with result", done, 1);
      chk(count_bad_code(out_digits) == 0, "R1 digit code", count_bad_code(out_digits), 0);
      chk(sum_digits(out_digits) == v, "R2 digit sum", sum_digits(out_digits), v);
      chk(count_adj(out_digits) == 0, "R3 adjacent nonzero", count_adj(out_digits), 0);
      chk(int'(out_nz_count) == count_nz(out_digits), "R4 nz count", int'(out_nz_count), count_nz(out_digits));
      chk(int'(out_nz_count) <= (N + 2) / 2, "R4 nz bound", int'(out_nz_count), (N + 2) / 2);
      chk($signed(out_value) == v, "R5 value", int'($signed(out_value)), v);
      release_out();
    end
  endtask

  task automatic t_backpressure();
    logic [2*DIG_N-1:0] held;
    int lat;
    // a second offer during the run must be ignored
    @(negedge clk);
    in_data  = 8'd111;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!in_ready, "R6 in_ready low while busy", in_ready, 0);
    in_data = 8'd42;
    lat = 0;
    while (!out_valid && lat < 40) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    chk(lat == DIG_N, "R7 latency under busy offer", lat, DIG_N);
    chk($signed(out_value) == 111, "R6 ignored offer", int'($signed(out_value)), 111);
    held = out_digits;
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      chk(out_valid, "R8 valid held", out_valid, 1);
      chk(out_digits == held, "R8 digits held", int'(out_digits), int'(held));
      chk(!done, "R9 done single cycle", done, 0);
      chk(!in_ready, "R6 in_ready low while holding", in_ready, 0);
    end
    in_valid = 1'b0;
    release_out();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_known(111, 7, 4, 0, 3);
    t_known(255, 8, 0, -1, 2);
    t_known(0, -1, -1, -1, 0);
    t_known(171, -1, -1, -1, -1);
    t_backpressure();
    t_exhaustive();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule